// File: doc/BRIEF.md
# Write-Back Four-Way Data Cache

This block sits between a processor load/store port and a line-wide memory port. It holds 8 KiB of data as 128 lines of 64 bytes, organised as 32 sets of four ways. Each way keeps a tag, a valid flag, a dirty flag and a 2-bit recency age. A processor request is taken in one cycle and checked in the next. A hit is answered in that second cycle and never reaches memory. Stores only mark their line dirty. Memory sees a line again only when that line is chosen as a victim.

On a miss the controller picks a victim in the indexed set. An empty way is used first. Otherwise the least recently used way is taken. A dirty victim is first written back as a full line, then the missing line is read. The request is then completed from the freshly filled line. A store miss places its word into the filled line and marks the line dirty.

The controller has five states: IDLE, LOOKUP, WRITEBACK, FILL and RESPOND. It moves through them as follows:
- IDLE goes to LOOKUP when a request is accepted.
- LOOKUP on a hit returns to IDLE, or stays in LOOKUP if a new request is accepted in the same cycle.
- LOOKUP on a miss goes to WRITEBACK when the victim is dirty, otherwise to FILL.
- WRITEBACK goes to FILL once memory takes the line.
- FILL goes to RESPOND when the read data arrives.
- RESPOND goes back to IDLE.

Top module: `wb_dcache`

## Requirements
- R1: The byte address splits into tag = bits [31:11], set index = bits [10:6] and word select = bits [5:2]. Bits [1:0] are ignored. Every memory request carries a line-aligned address: the low six bits are zero and the upper bits are the line's tag and index.
- R2: After reset every way is invalid. While idle, `cpu_stall`, `cpu_resp_valid` and `mem_valid` are all low.
- R3: A hit is answered in the cycle after the request was accepted. In that cycle `cpu_resp_valid` is high, `cpu_stall` is low and no memory transaction is made.
- R4: A store hit updates only the selected word and marks the line dirty. No memory write is made.
- R5: A read miss with an empty or clean victim makes exactly one memory transaction, a line read. The response then returns the addressed word of the filled line.
- R6: A miss whose victim is dirty makes two memory transactions, strictly in this order: first a write of the victim line to its own address, carrying all stored words, then a read of the new line.
- R7: A store miss fills the line from memory, then writes the store word into it and marks it dirty. The other words of the line keep their memory values.
- R8: The victim is the lowest-numbered invalid way if the set has one. Otherwise it is the least recently used way, where recency is updated on every hit and every fill.
- R9: `cpu_stall` is high in every cycle from a missing lookup through the RESPOND cycle. A request is taken only in a cycle where `cpu_stall` is low.
- R10: `mem_valid`, `mem_addr` and `mem_we` stay stable until `mem_ready` is high. Read data is taken only on `mem_rvalid` after the read request has been accepted.
- R11: In the cycle a hit is answered, a new request may be accepted, giving back-to-back hits one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store word |
| cpu_stall | output | 1 | Cache busy; request not taken |
| cpu_resp_valid | output | 1 | Response for the current request |
| cpu_rdata | output | 32 | Load data, valid with the response |
| mem_valid | output | 1 | Line request to memory |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned address |
| mem_wdata | output | 512 | Line being written back |
| mem_ready | input | 1 | Memory takes the request |
| mem_rvalid | input | 1 | Read line is present |
| mem_rdata | input | 512 | Read line data |

## Verification
The cache is driven with several access patterns, and each one separates different behaviour:
- A cold load against a repeat load of another word in the same line separates the fill path from the hit path.
- A store followed by a reload shows that the store stays in the cache and never reaches memory.
- Filling one set with four tags, touching one of them and then bringing in a fifth shows which way is evicted: recency replacement gives a different victim than plain order.
- A store miss, a later dirty eviction and a reload of the evicted line show that the merged word is written back and is written back before the fill.
- The same pattern is repeated with a memory that is ready only every other cycle.
- Held requests test back-to-back hits.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;
    parameter int ADDR_W     = 32;
    parameter int WORD_W     = 32;
    parameter int WAYS       = 4;
    parameter int SETS       = 32;
    parameter int LINE_BYTES = 64;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WPL    = LINE_BYTES / (WORD_W / 8);
    localparam int WSEL_W = $clog2(WPL);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINES  = SETS * WAYS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_FILL,
        ST_RESPOND
    } dc_state_e;
endpackage

// File: rtl/wb_dcache_tags.sv
module wb_dcache_tags
    import wb_dcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic [WAY_W-1:0] way,
    input  logic             touch_en,
    input  logic             fill_en,
    input  logic             dirty_en,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_dirty,
    output logic [TAG_W-1:0] sel_tag
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  dty_q [SETS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[idx][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[idx][w]) victim_way = WAY_W'(w);
        end
        victim_dirty = vld_q[idx][victim_way] && dty_q[idx][victim_way];
        sel_tag      = tag_q[idx][way];
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx][way] <= tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                dty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            if (fill_en) begin
                vld_q[idx][way] <= 1'b1;
                dty_q[idx][way] <= 1'b0;
            end
            if (dirty_en) dty_q[idx][way] <= 1'b1;
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == way)
                        age_q[idx][w] <= '0;
                    else if (age_q[idx][w] < age_q[idx][way])
                        age_q[idx][w] <= age_q[idx][w] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wb_dcache_data.sv
module wb_dcache_data
    import wb_dcache_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WAY_W-1:0]  way,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [WORD_W-1:0] wword,
    output logic [LINE_W-1:0] line
);
    logic [LINE_W-1:0] line_q [LINES];
    logic [IDX_W+WAY_W-1:0] slot;

    assign slot = {idx, way};
    assign line = line_q[slot];

    always_ff @(posedge clk) begin
        if (fill_en)
            line_q[slot] <= fill_line;
        else if (wr_en)
            line_q[slot][wsel*WORD_W +: WORD_W] <= wword;
    end
endmodule

// File: rtl/wb_dcache_ctrl.sv
module wb_dcache_ctrl
    import wb_dcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic [WAY_W-1:0]  victim_way,
    input  logic              victim_dirty,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    output dc_state_e         state,
    output logic [ADDR_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata,
    output logic [WAY_W-1:0]  act_way,
    output logic              cpu_stall,
    output logic              cpu_resp_valid,
    output logic              touch_en,
    output logic              fill_en,
    output logic              wr_en,
    output logic              mem_valid,
    output logic              mem_we
);
    dc_state_e        state_q, state_d;
    logic             we_q, issued_q, accept, lookup_hit;
    logic [WAY_W-1:0] vway_q;

    assign state      = state_q;
    assign lookup_hit = (state_q == ST_LOOKUP) && hit;
    assign accept     = cpu_req && !cpu_stall;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_LOOKUP;
            ST_LOOKUP:    if (hit) state_d = accept ? ST_LOOKUP : ST_IDLE;
                          else     state_d = victim_dirty ? ST_WRITEBACK : ST_FILL;
            ST_WRITEBACK: if (mem_ready) state_d = ST_FILL;
            ST_FILL:      if (issued_q && mem_rvalid) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_stall      = !((state_q == ST_IDLE) || lookup_hit);
        cpu_resp_valid = lookup_hit || (state_q == ST_RESPOND);
        act_way        = (state_q == ST_LOOKUP) ? hit_way : vway_q;
        fill_en        = (state_q == ST_FILL) && issued_q && mem_rvalid;
        touch_en       = lookup_hit || fill_en;
        wr_en          = we_q && (lookup_hit || (state_q == ST_RESPOND));
        mem_valid      = (state_q == ST_WRITEBACK) || ((state_q == ST_FILL) && !issued_q);
        mem_we         = (state_q == ST_WRITEBACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            we_q      <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            vway_q    <= '0;
            issued_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                we_q      <= cpu_we;
                req_addr  <= cpu_addr;
                req_wdata <= cpu_wdata;
            end
            if ((state_q == ST_LOOKUP) && !hit) vway_q <= victim_way;
            issued_q <= (state_q == ST_FILL) && !fill_en && (issued_q || mem_ready);
        end
    end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wb_dcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [LINE_W-1:0] mem_rdata
);
    dc_state_e         fsm_state;
    logic [ADDR_W-1:0] req_addr;
    logic [WORD_W-1:0] req_wdata;
    logic [WAY_W-1:0]  act_way, hit_way, victim_way;
    logic              hit, victim_dirty, touch_en, fill_en, wr_en;
    logic [TAG_W-1:0]  sel_tag, req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic [LINE_W-1:0] line;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_wsel = req_addr[BYTE_W +: WSEL_W];

    wb_dcache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way), .victim_dirty(victim_dirty),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .state(fsm_state), .req_addr(req_addr), .req_wdata(req_wdata), .act_way(act_way),
        .cpu_stall(cpu_stall), .cpu_resp_valid(cpu_resp_valid),
        .touch_en(touch_en), .fill_en(fill_en), .wr_en(wr_en),
        .mem_valid(mem_valid), .mem_we(mem_we)
    );

    wb_dcache_tags u_tags (
        .clk(clk), .rst_n(rst_n), .idx(req_idx), .tag(req_tag), .way(act_way),
        .touch_en(touch_en), .fill_en(fill_en), .dirty_en(wr_en),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
        .victim_dirty(victim_dirty), .sel_tag(sel_tag)
    );

    wb_dcache_data u_data (
        .clk(clk), .idx(req_idx), .way(act_way),
        .fill_en(fill_en), .fill_line(mem_rdata),
        .wr_en(wr_en), .wsel(req_wsel), .wword(req_wdata),
        .line(line)
    );

    assign cpu_rdata = line[req_wsel*WORD_W +: WORD_W];
    assign mem_wdata = line;
    assign mem_addr  = (fsm_state == ST_WRITEBACK) ? {sel_tag, req_idx, {OFF_W{1'b0}}}
                                                   : {req_tag, req_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk
    import wb_dcache_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input dc_state_e         state,
    input logic              cpu_stall,
    input logic              cpu_resp_valid,
    input logic              mem_valid,
    input logic              mem_we,
    input logic              mem_ready,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !cpu_stall && !cpu_resp_valid && !mem_valid); // R2

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[OFF_W-1:0] == '0); // R1

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid && !cpu_stall |-> !mem_valid); // R3

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R10

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && mem_ready |=> mem_valid && !mem_we); // R6

    AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FILL && !mem_valid && mem_rvalid |=> cpu_resp_valid && cpu_stall); // R5

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOOKUP && cpu_stall |=> cpu_stall); // R9
endmodule

bind wb_dcache wb_dcache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(fsm_state),
    .cpu_stall(cpu_stall), .cpu_resp_valid(cpu_resp_valid),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_addr(mem_addr)
);

// File: tb/wb_dcache_bench.sv
module wb_dcache_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic         cpu_stall, cpu_resp_valid;
    logic [31:0]  cpu_rdata;
    logic         mem_valid, mem_we;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic         mem_ready = 1'b1, mem_rvalid = 1'b0;
    logic [511:0] mem_rdata = '0;

    int n_tests = 0, n_fail = 0, stall_bad = 0, txn_total = 0;
    logic         slow_mem = 1'b0;
    logic [511:0] mem [1024];
    logic         log_we   [64];
    logic [31:0]  log_addr [64];
    logic [511:0] log_line [64];
    logic [31:0]  ref_w [logic [31:0]];

    always #5ns clk = ~clk;

    wb_dcache u_wb_dcache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
        .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A5A_0000 ^ (a & 32'h0000_FFFC);
    endfunction

    function automatic logic [31:0] ad(input int tag, input int idx, input int w);
        return 32'((tag << 11) | (idx << 6) | (w << 2));
    endfunction

    function automatic logic [31:0] expw(input logic [31:0] a);
        logic [31:0] k;
        k = a & ~32'h3;
        return ref_w.exists(k) ? ref_w[k] : pat(k);
    endfunction

    initial begin
        for (int l = 0; l < 1024; l++)
            for (int w = 0; w < 16; w++)
                mem[l][w*32 +: 32] = pat(32'(l * 64 + w * 4));
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_ready  <= slow_mem ? ~mem_ready : 1'b1;
        if (mem_valid && mem_ready) begin
            log_we[txn_total % 64]   <= mem_we;
            log_addr[txn_total % 64] <= mem_addr;
            log_line[txn_total % 64] <= mem_wdata;
            txn_total <= txn_total + 1;
            if (mem_we) mem[mem_addr[15:6]] <= mem_wdata;
            else begin
                mem_rdata  <= mem[mem_addr[15:6]];
                mem_rvalid <= 1'b1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat, output int ntx, output int first);
        first = txn_total;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        while (!cpu_resp_valid) begin
            if (!cpu_stall) stall_bad++;
            @(negedge clk);
            lat++;
        end
        rd = cpu_rdata;
        if (we) ref_w[a & ~32'h3] = wd;
        @(negedge clk);
        ntx = txn_total - first;
    endtask

    task automatic t_reset();
        chk("R2", "stall after reset", 64'(cpu_stall), 0);
        chk("R2", "resp after reset", 64'(cpu_resp_valid), 0);
        chk("R2", "mem_valid after reset", 64'(mem_valid), 0);
    endtask

    task automatic t_cold_and_hit();
        logic [31:0] rd; int lat, ntx, f;
        access(0, ad(1, 3, 5), 0, rd, lat, ntx, f);
        chk("R5", "cold read data", 64'(rd), 64'(pat(ad(1, 3, 5))));
        chk("R5", "cold read txns", 64'(ntx), 1);
        chk("R5", "fill is a read", 64'(log_we[f % 64]), 0);
        chk("R1", "fill address", 64'(log_addr[f % 64]), 64'(ad(1, 3, 0)));
        access(0, ad(1, 3, 9) | 32'h3, 0, rd, lat, ntx, f);
        chk("R1", "hit data, low bits ignored", 64'(rd), 64'(pat(ad(1, 3, 9))));
        chk("R3", "hit latency", 64'(lat), 1);
        chk("R3", "hit txns", 64'(ntx), 0);
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; int lat, ntx, f;
        access(1, ad(1, 3, 9), 32'hDEAD_BEEF, rd, lat, ntx, f);
        chk("R4", "write hit txns", 64'(ntx), 0);
        chk("R4", "write hit latency", 64'(lat), 1);
        access(0, ad(1, 3, 9), 0, rd, lat, ntx, f);
        chk("R4", "readback", 64'(rd), 64'(32'hDEAD_BEEF));
        access(0, ad(1, 3, 8), 0, rd, lat, ntx, f);
        chk("R4", "neighbour word", 64'(rd), 64'(pat(ad(1, 3, 8))));
    endtask

    task automatic t_lru();
        logic [31:0] rd; int lat, ntx, f;
        for (int t = 1; t <= 4; t++) begin
            access(0, ad(t, 7, 0), 0, rd, lat, ntx, f);
            chk("R8", "invalid way filled, no writeback", 64'(ntx), 1);
        end
        access(0, ad(1, 7, 1), 0, rd, lat, ntx, f);
        chk("R8", "all four resident", 64'(ntx), 0);
        access(0, ad(5, 7, 0), 0, rd, lat, ntx, f);
        chk("R8", "fifth tag clean evict", 64'(ntx), 1);
        access(0, ad(1, 7, 2), 0, rd, lat, ntx, f);
        chk("R8", "touched tag kept", 64'(ntx), 0);
        access(0, ad(2, 7, 3), 0, rd, lat, ntx, f);
        chk("R8", "LRU tag was evicted", 64'(ntx), 1);
        chk("R8", "refetched data", 64'(rd), 64'(pat(ad(2, 7, 3))));
    endtask

    task automatic t_dirty(input int set, input logic [31:0] val);
        logic [31:0] rd; int lat, ntx, f;
        access(1, ad(1, set, 2), val, rd, lat, ntx, f);
        chk("R7", "write miss fills", 64'(ntx), 1);
        chk("R7", "write miss fill is read", 64'(log_we[f % 64]), 0);
        access(0, ad(1, set, 2), 0, rd, lat, ntx, f);
        chk("R7", "merged word", 64'(rd), 64'(val));
        access(0, ad(1, set, 3), 0, rd, lat, ntx, f);
        chk("R7", "other word from memory", 64'(rd), 64'(expw(ad(1, set, 3))));
        for (int t = 2; t <= 4; t++) access(0, ad(t, set, 0), 0, rd, lat, ntx, f);
        access(0, ad(5, set, 1), 0, rd, lat, ntx, f);
        chk("R6", "dirty miss txns", 64'(ntx), 2);
        chk("R6", "first is writeback", 64'(log_we[f % 64]), 1);
        chk("R6", "writeback address", 64'(log_addr[f % 64]), 64'(ad(1, set, 0)));
        chk("R6", "writeback word", 64'(log_line[f % 64][2*32 +: 32]), 64'(val));
        chk("R6", "second is fill", 64'(log_we[(f + 1) % 64]), 0);
        chk("R6", "fill address", 64'(log_addr[(f + 1) % 64]), 64'(ad(5, set, 0)));
        chk("R6", "data after dirty miss", 64'(rd), 64'(pat(ad(5, set, 1))));
        access(0, ad(1, set, 2), 0, rd, lat, ntx, f);
        chk("R6", "written-back value returns", 64'(rd), 64'(val));
        chk("R6", "clean victim on reload", 64'(ntx), 1);
    endtask

    task automatic t_back2back();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ad(1, 3, 0);
        @(negedge clk);
        chk("R11", "first hit resp", 64'(cpu_resp_valid && !cpu_stall), 1);
        chk("R11", "first hit data", 64'(cpu_rdata), 64'(expw(ad(1, 3, 0))));
        cpu_addr = ad(1, 3, 15);
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R11", "second hit resp", 64'(cpu_resp_valid), 1);
        chk("R11", "second hit data", 64'(cpu_rdata), 64'(expw(ad(1, 3, 15))));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_and_hit();
        t_write_hit();
        t_lru();
        t_dirty(9, 32'hCAFE_0009);
        slow_mem = 1'b1;
        t_dirty(12, 32'hBEEF_0012);   // R10 with a slow memory
        slow_mem = 1'b0;
        t_back2back();
        chk("R9", "stall low while waiting", 64'(stall_bad), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule